// File: doc/BRIEF.md
# Byte-to-Word Boot Loader DMA

This block moves a run of bytes from a paged, byte-wide external memory into the program or data memory of a word-oriented DSP core. Software sets four registers: a destination word pointer, a byte offset within a page, a control word, and a word count. The control word holds the page, the packing mode, the direction and the completion action. Writing the word count starts the copy. Each destination word is assembled from one, two or three consecutive bytes, depending on the packing mode.

The engine reads one byte per clock from a synchronous byte memory with one cycle of read latency. It writes a destination word on the cycle that the last byte of that word arrives. When the copy ends, the count register reads zero and the offset and page fields hold the byte address that follows the last byte read. The block then raises a one-cycle completion interrupt, or a one-cycle core reset if the control word asks for one. A request to copy in the other direction, from the core out to byte memory, is refused: no bytes are read and an error flag is set instead.

Top module: `boot_dma`

## Requirements
- R1: Writes to the destination pointer (select 0), the byte offset (select 1) and the word count (select 3) keep only bits 13:0. Bits 15:14 read back as zero.
- R2: A write to the control word (select 2) keeps only the bits in mask 0xFF0F. Bits 15:8 are the page, bit 3 selects reset-on-completion, bit 2 is the direction, and bits 1:0 are the packing mode.
- R3: Mode 0 writes program memory (dst_prog_o=1) with a 24-bit word made from three consecutive bytes, first byte most significant. Each word advances the byte address by 3.
- R4: Mode 1 writes data memory (dst_prog_o=0) with {8'h00, first byte, second byte}. Each word advances the byte address by 2.
- R5: Mode 2 writes data memory with {8'h00, byte, 8'h00} and mode 3 writes data memory with {16'h0000, byte}. Each word advances the byte address by 1.
- R6: Words go to destination addresses pointer, pointer+1, and so on, modulo 2^14. After completion the pointer register reads its start value plus the count.
- R7: After completion the count reads 0, and {page, offset} reads the start byte address plus count times bytes-per-word, modulo 2^22.
- R8: With control bit 3 clear, completion gives a one-cycle done_irq_o pulse. With bit 3 set, it gives a one-cycle core_rst_o pulse instead. The two never coincide.
- R9: Writing the count while direction bit 2 is 1 reads no bytes, writes nothing, leaves busy_o low and sets dir_err_o. The flag stays set until the next accepted forward start.
- R10: While busy_o is 1, every register write is ignored.
- R11: Bytes are read in order from {page, offset}, one per clock with no gaps. busy_o stays high for exactly count times bytes-per-word plus 1 cycles.
- R12: Writing a count of 0 in the forward direction reads and writes nothing, leaves the registers unchanged, and gives the completion pulse on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 pointer, 1 offset, 2 control, 3 count |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Selected register contents (combinational) |
| bmem_re_o | output | 1 | Byte memory read enable |
| bmem_addr_o | output | 22 | Byte memory address |
| bmem_data_i | input | 8 | Byte memory data, valid one cycle after the read |
| dst_we_o | output | 1 | Destination word write strobe |
| dst_prog_o | output | 1 | 1 selects program memory, 0 selects data memory |
| dst_addr_o | output | 14 | Destination word address |
| dst_data_o | output | 24 | Destination word data |
| busy_o | output | 1 | Copy in progress |
| done_irq_o | output | 1 | One-cycle completion interrupt |
| core_rst_o | output | 1 | One-cycle core reset on completion |
| dir_err_o | output | 1 | Unsupported direction requested |

## Verification
On every cycle, the assertions check these properties: destination writes and byte reads occur only while busy, destination addresses step by one between back-to-back writes, and completion pulses last one cycle, never overlap, and always leave the count at zero. They also check that the error flag never rises during a copy. The packed word values, the final address and page write-back including the carry across the page boundary, and the ignoring of writes during a copy can only be shown by the bench's sweep over modes, counts and base addresses. The same holds for the exact busy length and the zero-count case.

// File: rtl/boot_dma_pkg.sv
package boot_dma_pkg;
  localparam int PAGE_W = 8;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 24;
  localparam logic [15:0] CTRL_MASK = 16'hFF0F;

  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_OFS  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_CNT  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    PK_PROG24 = 2'd0,
    PK_DATA16 = 2'd1,
    PK_HIBYTE = 2'd2,
    PK_LOBYTE = 2'd3
  } pack_mode_e;

  function automatic logic [1:0] bytes_per_word(input logic [1:0] mode);
    case (mode)
      PK_PROG24: return 2'd3;
      PK_DATA16: return 2'd2;
      default:   return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/boot_dma_issue.sv
module boot_dma_issue #(
  parameter int ADDR_W = 14,
  parameter int BA_W   = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BA_W-1:0]   start_addr_i,
  input  logic [1:0]        nb_i,
  input  logic [ADDR_W-1:0] words_i,
  output logic              re_o,
  output logic [BA_W-1:0]   addr_o,
  output logic              last_byte_o
);
  logic [BA_W-1:0]   ptr_q;
  logic [1:0]        idx_q;
  logic [ADDR_W-1:0] left_q;
  logic              act_q;

  assign re_o        = act_q;
  assign addr_o      = ptr_q;
  assign last_byte_o = act_q && (idx_q == nb_i - 2'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      idx_q  <= '0;
      left_q <= '0;
      act_q  <= 1'b0;
    end else if (start_i) begin
      ptr_q  <= start_addr_i;
      idx_q  <= '0;
      left_q <= words_i;
      act_q  <= 1'b1;
    end else if (act_q) begin
      ptr_q <= ptr_q + 1'b1;
      if (last_byte_o) begin
        idx_q  <= '0;
        left_q <= left_q - 1'b1;
        if (left_q == {{(ADDR_W-1){1'b0}}, 1'b1}) act_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 2'd1;
      end
    end
  end
endmodule

// File: rtl/boot_dma_pack.sv
module boot_dma_pack import boot_dma_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic              last_i,
  input  logic [1:0]        mode_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              pend_o,
  output logic              we_o,
  output logic [WORD_W-1:0] word_o
);
  logic        rv_q, rlast_q;
  logic [15:0] acc_q;

  assign pend_o = rv_q;
  assign we_o   = rv_q && rlast_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rv_q    <= 1'b0;
      rlast_q <= 1'b0;
      acc_q   <= '0;
    end else begin
      rv_q    <= re_i;
      rlast_q <= last_i;
      if (rv_q) acc_q <= {acc_q[7:0], byte_i};
    end
  end

  always_comb begin
    case (mode_i)
      PK_PROG24: word_o = {acc_q, byte_i};
      PK_DATA16: word_o = {8'h00, acc_q[7:0], byte_i};
      PK_HIBYTE: word_o = {8'h00, byte_i, 8'h00};
      default:   word_o = {16'h0000, byte_i};
    endcase
  end
endmodule

// File: rtl/boot_dma.sv
module boot_dma import boot_dma_pkg::*; #(
  parameter int ADDR_W = 14
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     reg_we_i,
  input  logic [1:0]               reg_sel_i,
  input  logic [15:0]              reg_wdata_i,
  output logic [15:0]              reg_rdata_o,
  output logic                     bmem_re_o,
  output logic [ADDR_W+PAGE_W-1:0] bmem_addr_o,
  input  logic [BYTE_W-1:0]        bmem_data_i,
  output logic                     dst_we_o,
  output logic                     dst_prog_o,
  output logic [ADDR_W-1:0]        dst_addr_o,
  output logic [WORD_W-1:0]        dst_data_o,
  output logic                     busy_o,
  output logic                     done_irq_o,
  output logic                     core_rst_o,
  output logic                     dir_err_o
);
  localparam int BA_W = ADDR_W + PAGE_W;

  logic [ADDR_W-1:0] ptr_q, ofs_q, cnt_q;
  logic [15:0]       ctrl_q;
  logic              done_q, rst_q, err_q;

  logic [ADDR_W-1:0] wval;
  logic              wr_ok, start, go, zero, bad_dir, fin;
  logic              iss_last, pk_pend, pk_we;
  logic [BA_W-1:0]   iss_addr;
  logic [1:0]        nb;

  assign wval    = reg_wdata_i[ADDR_W-1:0];
  assign wr_ok   = reg_we_i && !busy_o;
  assign start   = wr_ok && (reg_sel_i == SEL_CNT);
  assign bad_dir = start && ctrl_q[2];
  assign go      = start && !ctrl_q[2] && (wval != '0);
  assign zero    = start && !ctrl_q[2] && (wval == '0);
  assign nb      = bytes_per_word(ctrl_q[1:0]);
  assign fin     = pk_we && !bmem_re_o;

  boot_dma_issue #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_issue (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (go),
    .start_addr_i ({ctrl_q[15:8], ofs_q}),
    .nb_i         (nb),
    .words_i      (wval),
    .re_o         (bmem_re_o),
    .addr_o       (iss_addr),
    .last_byte_o  (iss_last)
  );

  boot_dma_pack u_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .re_i   (bmem_re_o),
    .last_i (iss_last),
    .mode_i (ctrl_q[1:0]),
    .byte_i (bmem_data_i),
    .pend_o (pk_pend),
    .we_o   (pk_we),
    .word_o (dst_data_o)
  );

  assign bmem_addr_o = iss_addr;
  assign busy_o      = bmem_re_o || pk_pend;
  assign dst_we_o    = pk_we;
  assign dst_prog_o  = (ctrl_q[1:0] == PK_PROG24);
  assign dst_addr_o  = ptr_q;
  assign done_irq_o  = done_q;
  assign core_rst_o  = rst_q;
  assign dir_err_o   = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      ofs_q  <= '0;
      ctrl_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      rst_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (reg_sel_i)
          SEL_PTR:  ptr_q  <= wval;
          SEL_OFS:  ofs_q  <= wval;
          SEL_CTRL: ctrl_q <= reg_wdata_i & CTRL_MASK;
          default:  cnt_q  <= wval;
        endcase
      end
      if (pk_we) ptr_q <= ptr_q + 1'b1;
      if (fin) begin
        ofs_q         <= iss_addr[ADDR_W-1:0];
        ctrl_q[15:8]  <= iss_addr[BA_W-1:ADDR_W];
        cnt_q         <= '0;
      end
      done_q <= (fin || zero) && !ctrl_q[3];
      rst_q  <= (fin || zero) && ctrl_q[3];
      if (bad_dir)        err_q <= 1'b1;
      else if (go || zero) err_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_sel_i)
      SEL_PTR:  reg_rdata_o[ADDR_W-1:0] = ptr_q;
      SEL_OFS:  reg_rdata_o[ADDR_W-1:0] = ofs_q;
      SEL_CTRL: reg_rdata_o = ctrl_q;
      default:  reg_rdata_o[ADDR_W-1:0] = cnt_q;
    endcase
  end
endmodule

// File: rtl/boot_dma_chk.sv
module boot_dma_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              bmem_re_o,
  input logic              dst_we_o,
  input logic [ADDR_W-1:0] dst_addr_o,
  input logic              done_irq_o,
  input logic              core_rst_o,
  input logic              dir_err_o,
  input logic [ADDR_W-1:0] cnt_q
);
  // R11
  write_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_we_o || bmem_re_o) |-> busy_o);
  // R6
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_we_o |=> (!dst_we_o || dst_addr_o == $past(dst_addr_o) + 1'b1));
  // R8
  no_both_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_irq_o && core_rst_o));
  // R8
  done_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_irq_o || core_rst_o) |=> !(done_irq_o || core_rst_o));
  // R7
  cnt_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_irq_o || core_rst_o) |-> (cnt_q == '0 && !busy_o));
  // R9
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dir_err_o) |-> !busy_o);
endmodule

bind boot_dma boot_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .bmem_re_o  (bmem_re_o),
  .dst_we_o   (dst_we_o),
  .dst_addr_o (dst_addr_o),
  .done_irq_o (done_irq_o),
  .core_rst_o (core_rst_o),
  .dir_err_o  (dir_err_o),
  .cnt_q      (cnt_q)
);

// File: tb/boot_dma_tb_top.sv
module boot_dma_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [15:0] wd = 16'h0;
  logic [15:0] rd;
  logic        re;
  logic [21:0] baddr;
  logic [7:0]  bq = 8'h0;
  logic        dwe, dprog, busy, dirq, crst, derr;
  logic [13:0] daddr;
  logic [23:0] ddata;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // expectation state for the monitors
  int          exp_mode = 0;
  logic [21:0] exp_ba = '0;
  logic [13:0] exp_ptr = '0;
  int          wr_idx = 0;
  int          rd_idx = 0;
  int          busy_cnt = 0;
  int          irq_cnt = 0;
  int          rstp_cnt = 0;

  always #5 clk = ~clk;

  boot_dma dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .bmem_re_o(re), .bmem_addr_o(baddr),
    .bmem_data_i(bq), .dst_we_o(dwe), .dst_prog_o(dprog), .dst_addr_o(daddr),
    .dst_data_o(ddata), .busy_o(busy), .done_irq_o(dirq), .core_rst_o(crst),
    .dir_err_o(derr)
  );

  function automatic logic [7:0] bfun(input logic [21:0] a);
    return (a[7:0] ^ a[15:8] ^ {a[21:16], 2'b01}) + 8'h5a;
  endfunction

  function automatic int nbytes(input int m);
    return (m == 0) ? 3 : (m == 1) ? 2 : 1;
  endfunction

  function automatic logic [23:0] exp_word(input int m, input logic [21:0] a);
    case (m)
      0: return {bfun(a), bfun(a + 22'd1), bfun(a + 22'd2)};
      1: return {8'h00, bfun(a), bfun(a + 22'd1)};
      2: return {8'h00, bfun(a), 8'h00};
      default: return {16'h0000, bfun(a)};
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (re) bq <= bfun(baddr);

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (busy) busy_cnt++;
    if (dirq) irq_cnt++;
    if (crst) rstp_cnt++;
    if (re) begin
      chk(baddr == exp_ba + 22'(rd_idx), "R11 byte addr", 32'(baddr), 32'(exp_ba + 22'(rd_idx)));
      rd_idx++;
    end
    if (dwe) begin
      logic [23:0] ew;
      ew = exp_word(exp_mode, exp_ba + 22'(wr_idx * nbytes(exp_mode)));
      chk(ddata == ew, exp_mode == 0 ? "R3 data" : exp_mode == 1 ? "R4 data" : "R5 data", 32'(ddata), 32'(ew));
      chk(dprog == (exp_mode == 0), "R3 mem select", 32'(dprog), 32'(exp_mode == 0));
      chk(daddr == exp_ptr + 14'(wr_idx), "R6 dst addr", 32'(daddr), 32'(exp_ptr + 14'(wr_idx)));
      wr_idx++;
    end
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", 32'(cyc), 32'd150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] s, output logic [15:0] v);
    sel = s;
    #1;
    v = rd;
  endtask

  task automatic clear_mon();
    wr_idx = 0; rd_idx = 0; busy_cnt = 0; irq_cnt = 0; rstp_cnt = 0;
  endtask

  task automatic run(input int m, input int n, input logic [13:0] ofs,
                     input logic [7:0] pg, input logic [13:0] p0, input bit rbit,
                     input bit poke);
    logic [15:0] v;
    logic [21:0] fin;
    wr(2'd0, {2'b11, p0});
    wr(2'd1, {2'b10, ofs});
    wr(2'd2, {pg, 4'hF, rbit, 1'b0, 2'(m)} );
    exp_mode = m; exp_ba = {pg, ofs}; exp_ptr = p0;
    clear_mon();
    wr(2'd3, 16'(n));
    if (poke) begin
      wr(2'd0, 16'h1234);
      wr(2'd3, 16'h0005);
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    fin = exp_ba + 22'(n * nbytes(m));
    chk(wr_idx == n, "R6 word count", 32'(wr_idx), 32'(n));
    chk(busy_cnt == n * nbytes(m) + 1, "R11 busy length", 32'(busy_cnt), 32'(n * nbytes(m) + 1));
    chk(irq_cnt == (rbit ? 0 : 1) && rstp_cnt == (rbit ? 1 : 0), "R8 pulse",
        32'({irq_cnt[15:0], rstp_cnt[15:0]}), 32'({15'd0, !rbit, 15'd0, rbit}));
    rdreg(2'd3, v); chk(v == 16'h0, "R7 count zero", 32'(v), 32'h0);
    rdreg(2'd1, v); chk(v == {2'b00, fin[13:0]}, "R7 offset", 32'(v), 32'(fin[13:0]));
    rdreg(2'd2, v); chk(v == {fin[21:14], 4'h0, rbit, 1'b0, 2'(m)}, "R7 page", 32'(v),
                        32'({fin[21:14], 4'h0, rbit, 1'b0, 2'(m)}));
    rdreg(2'd0, v); chk(v == {2'b00, p0 + 14'(n)}, poke ? "R10 ptr" : "R6 ptr", 32'(v), 32'(p0 + 14'(n)));
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rdreg(2'd2, v); chk(v == 16'h0 && !busy && !dirq && !crst && !derr, "R2 reset state", 32'(v), 32'h0);
    rst_n = 1'b1;
    // R1 / R2 masks
    wr(2'd0, 16'hFFFF); rdreg(2'd0, v); chk(v == 16'h3FFF, "R1 ptr mask", 32'(v), 32'h3FFF);
    wr(2'd1, 16'hC123); rdreg(2'd1, v); chk(v == 16'h0123, "R1 ofs mask", 32'(v), 32'h0123);
    wr(2'd2, 16'hFFF8); rdreg(2'd2, v); chk(v == 16'hFF08, "R2 ctrl mask", 32'(v), 32'hFF08);
    // R12 zero count: reset bit set
    clear_mon();
    wr(2'd3, 16'hC000);
    repeat (2) @(negedge clk);
    chk(rstp_cnt == 1 && irq_cnt == 0 && wr_idx == 0 && rd_idx == 0 && busy_cnt == 0,
        "R12 zero count", 32'({rstp_cnt[7:0], irq_cnt[7:0], wr_idx[7:0], busy_cnt[7:0]}), 32'h01000000);
    rdreg(2'd1, v); chk(v == 16'h0123, "R12 regs kept", 32'(v), 32'h0123);
    rdreg(2'd3, v); chk(v == 16'h0, "R1 count mask", 32'(v), 32'h0);
    // R9 direction error
    wr(2'd2, 16'h0004);
    clear_mon();
    wr(2'd3, 16'd4);
    repeat (4) @(negedge clk);
    chk(derr && busy_cnt == 0 && rd_idx == 0 && wr_idx == 0 && irq_cnt == 0 && rstp_cnt == 0,
        "R9 dir error", 32'({derr, busy_cnt[7:0]}), 32'h100);
    // sweep
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 3; c++) begin
        for (int b = 0; b < 3; b++) begin
          int n;
          logic [13:0] o;
          logic [7:0] pg;
          n  = (c == 0) ? 1 : (c == 1) ? 3 : 7;
          o  = (b == 0) ? 14'h0010 : (b == 1) ? 14'h3FFD : 14'h3FFF;
          pg = (b == 0) ? 8'h00 : (b == 1) ? 8'h2A : 8'hFF;
          run(m, n, o, pg, (b == 2) ? 14'h3FFE : 14'(40 * m + c), ((m + b) & 1) == 1, 1'b0);
          if (m == 0 && c == 0 && b == 0)
            chk(!derr, "R9 flag cleared", 32'(derr), 32'h0);
        end
      end
    end
    // R10 writes during busy ignored
    run(0, 5, 14'h0100, 8'h03, 14'h0020, 1'b0, 1'b1);
    run(3, 6, 14'h0200, 8'h01, 14'h0030, 1'b1, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule